// File: doc/BRIEF.md
# Dual-Channel Serial Port Framer

This block is a serial port with two data lanes, A and B, that share one frame sync and one bit timing. The block clock is the bit clock: each clock cycle carries one serial bit. Each lane owns a two-word buffer. In transmit direction the core fills the buffers and the framer drains them. In receive direction the framer fills them and the core drains them.

The framer decides when a frame may start by looking at how full both buffers are. It then drives a one-cycle frame sync pulse. Both enabled lanes shift a full word, most significant bit first, starting in the cycle after that pulse.

Core accesses pass through a register-style port, and that port can hold the core off with a stall signal while a buffer is full or empty. A hang-disable input replaces the stall with a dropped write or a stale read. Sticky underflow and overflow flags record lane errors, and the core clears them by writing ones.

Top module: `dual_sport_framer`

## Requirements
- R1: In transmit direction with `fs_both`=1 and both lanes enabled, a frame starts only when both transmit buffers hold at least one word.
- R2: In transmit direction with joint mode not in effect, a frame starts when any enabled lane's buffer holds a word. An enabled lane whose buffer is empty still takes part in that frame.
- R3: In receive direction with `fs_both`=1 and both lanes enabled, no frame starts while either receive buffer is full. Otherwise a frame starts when any enabled lane's buffer is not full.
- R4: With exactly one lane enabled, frame gating uses the non-joint rule, whatever `fs_both` says.
- R5: A disabled lane takes no part in frame gating. Its serial output stays 0 and it receives no data.
- R6: Frame timing:
  - `fs` is high for exactly one cycle, and its data lines are 0 in that cycle.
  - The next W cycles carry bits W-1 down to 0 on every enabled lane at once.
  - Back-to-back frames repeat every W+2 cycles.
  - Each buffer is first-in first-out.
- R7: A lane that is enabled at frame start with an empty transmit buffer sends all zeros and sets its sticky underflow flag (flags bit 0 = lane A, bit 1 = lane B).
- R8: With `hang_dis`=0, `core_stall` is high, in the same cycle, while the core writes a full transmit buffer or reads an empty receive buffer. The access completes in the first cycle the stall is low.
- R9: With `hang_dis`=1, `core_stall` never rises. A write to a full buffer is discarded, and a read from an empty buffer leaves `core_rdata` at its previous value.
- R10: A word that completes while its receive buffer is full is discarded and sets a sticky overflow flag (bit 2 = lane A, bit 3 = lane B). Writing 1 to a flag bit at address 2 clears it.
- R11: Synchronous active-high `rst` empties both buffers, clears all flags and `core_rdata`, and holds `fs`, `core_stall` and the data lines low.
- R12: Address decoding:
  - Addresses 0 and 1 select the data buffers of lanes A and B.
  - Address 2 is the flag word, with bits above 3 reading as zero.
  - A completed read updates `core_rdata` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_dir | input | 1 | 1 = transmit direction, 0 = receive direction |
| en_a | input | 1 | Lane A enable |
| en_b | input | 1 | Lane B enable |
| fs_both | input | 1 | Joint frame gating mode when both lanes are enabled |
| hang_dis | input | 1 | 1 = never stall; drop full writes, stale empty reads |
| core_wr | input | 1 | Core write request, held while stalled |
| core_rd | input | 1 | Core read request, held while stalled |
| core_addr | input | 2 | 0 = lane A data, 1 = lane B data, 2 = flags |
| core_wdata | input | W | Core write data |
| core_rdata | output | W | Registered core read data |
| core_stall | output | 1 | Hold-off toward the core |
| fs | output | 1 | Frame sync pulse |
| tx_a | output | 1 | Lane A serial output |
| tx_b | output | 1 | Lane B serial output |
| rx_a | input | 1 | Lane A serial input |
| rx_b | input | 1 | Lane B serial input |

## Verification
- **Frame start:** A frame is decided at the edge where the framer is idle and the gating holds. `fs` is then high during the following cycle, and the MSB appears on the lines in the cycle after that. The bench therefore finds the frame by polling `fs` at falling edges, and it reads or drives one bit at each of the next W falling edges.
- **Stall:** `core_stall` is combinational. It is sampled 2 ns after the request is set, within the same cycle.
- **Read data:** `core_rdata` and the flags are read at the falling edge after the edge that completes the access.
- **Receive buffer:** A received word enters its buffer at the edge that ends its last bit. Full/empty effects are therefore tested only after that edge.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  localparam logic [1:0] AD_LANE_A = 2'd0;
  localparam logic [1:0] AD_LANE_B = 2'd1;
  localparam logic [1:0] AD_FLAGS  = 2'd2;

  // joint gating only applies when every lane is enabled
  function automatic logic joint_mode(input logic both_bit, input logic [NCH-1:0] en);
    return both_bit & (&en);
  endfunction

  // a lane is ready when it can give (tx) or take (rx) one word
  function automatic logic frame_ok(input logic tx, input logic joint,
                                    input logic [NCH-1:0] en,
                                    input logic [NCH-1:0] empty,
                                    input logic [NCH-1:0] full);
    logic [NCH-1:0] ready;
    ready = tx ? ~empty : ~full;
    if (joint) return &ready;
    return |(en & ready);
  endfunction

  function automatic logic [3:0] pack_flags(input logic [NCH-1:0] unf, input logic [NCH-1:0] ovf);
    return {ovf, unf};
  endfunction
endpackage

// File: rtl/dsf_buf.sv
module dsf_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dsf_lane.sv
module dsf_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] word_in
);
  logic [W-1:0] sh;

  assign ser_out = sh[W-1];
  assign word_in = {sh[W-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= load_word;
    else if (shift) sh <= {sh[W-2:0], ser_in};
  end
endmodule

// File: rtl/dsf_frame.sv
module dsf_frame
  import dsf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  output phase_t phase,
  output logic   start,
  output logic   last_bit
);
  localparam int CNTW = (W > 1) ? $clog2(W) : 1;

  logic [CNTW-1:0] cnt;

  assign start    = (phase == PH_IDLE) & go;
  assign last_bit = (phase == PH_DATA) && (cnt == CNTW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (go) phase <= PH_SYNC;
        PH_SYNC: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          if (last_bit) phase <= PH_IDLE;
          cnt <= cnt + CNTW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsf_core_if.sv
module dsf_core_if
  import dsf_pkg::*;
(
  input  logic           tx_dir,
  input  logic           hang_dis,
  input  logic           core_wr,
  input  logic           core_rd,
  input  logic [1:0]     core_addr,
  input  logic [NCH-1:0] full,
  input  logic [NCH-1:0] empty,
  output logic           core_stall,
  output logic [NCH-1:0] push_core,
  output logic [NCH-1:0] pop_core,
  output logic           flag_wr,
  output logic           flag_rd
);
  logic [NCH-1:0] blocked;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic sel, wr_hit, rd_hit;
      sel          = (core_addr == 2'(c));
      wr_hit       = core_wr & sel & tx_dir;
      rd_hit       = core_rd & sel & ~tx_dir;
      push_core[c] = wr_hit & ~full[c];
      pop_core[c]  = rd_hit & ~empty[c];
      blocked[c]   = (wr_hit & full[c]) | (rd_hit & empty[c]);
    end
  end

  assign core_stall = ~hang_dis & (|blocked);
  assign flag_wr    = core_wr & (core_addr == AD_FLAGS);
  assign flag_rd    = core_rd & (core_addr == AD_FLAGS);
endmodule

// File: rtl/dual_sport_framer.sv
module dual_sport_framer
  import dsf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_dir,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         fs_both,
  input  logic         hang_dis,
  input  logic         core_wr,
  input  logic         core_rd,
  input  logic [1:0]   core_addr,
  input  logic [W-1:0] core_wdata,
  output logic [W-1:0] core_rdata,
  output logic         core_stall,
  output logic         fs,
  output logic         tx_a,
  output logic         tx_b,
  input  logic         rx_a,
  input  logic         rx_b
);
  logic [NCH-1:0] en, rx_in, ser_out, line;
  logic [NCH-1:0] full, empty, push, pop, push_core, pop_core;
  logic [NCH-1:0] act, unf, ovf, set_unf, set_ovf, eng_push, eng_pop, lane_load;
  logic [W-1:0]   head [NCH];
  logic [W-1:0]   din [NCH];
  logic [W-1:0]   word_in [NCH];
  logic [W-1:0]   load_word [NCH];
  logic           joint, go, start, last_bit, in_data, flag_wr, flag_rd;
  logic [3:0]     flag_clr;
  phase_t         phase;

  assign en      = {en_b, en_a};
  assign rx_in   = {rx_b, rx_a};
  assign joint   = joint_mode(fs_both, en);
  assign go      = frame_ok(tx_dir, joint, en, empty, full);
  assign in_data = (phase == PH_DATA);
  assign fs      = (phase == PH_SYNC);
  assign tx_a    = line[0];
  assign tx_b    = line[1];

  dsf_frame #(.W(W)) u_frame (
    .clk(clk), .rst(rst), .go(go),
    .phase(phase), .start(start), .last_bit(last_bit)
  );

  dsf_core_if u_core (
    .tx_dir(tx_dir), .hang_dis(hang_dis), .core_wr(core_wr), .core_rd(core_rd),
    .core_addr(core_addr), .full(full), .empty(empty), .core_stall(core_stall),
    .push_core(push_core), .pop_core(pop_core), .flag_wr(flag_wr), .flag_rd(flag_rd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign eng_pop[c]   = tx_dir & start & en[c] & ~empty[c];
    assign set_unf[c]   = tx_dir & start & en[c] & empty[c];
    assign lane_load[c] = tx_dir & start & en[c];
    assign eng_push[c]  = ~tx_dir & last_bit & act[c] & ~full[c];
    assign set_ovf[c]   = ~tx_dir & last_bit & act[c] & full[c];
    assign push[c]      = tx_dir ? push_core[c] : eng_push[c];
    assign pop[c]       = tx_dir ? eng_pop[c] : pop_core[c];
    assign din[c]       = tx_dir ? core_wdata : word_in[c];
    assign load_word[c] = empty[c] ? '0 : head[c];
    assign line[c]      = tx_dir & in_data & act[c] & ser_out[c];

    dsf_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst(rst), .push(push[c]), .pop(pop[c]), .din(din[c]),
      .head(head[c]), .full(full[c]), .empty(empty[c])
    );

    dsf_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .load(lane_load[c]), .load_word(load_word[c]),
      .shift(in_data & act[c]), .ser_in(rx_in[c]),
      .ser_out(ser_out[c]), .word_in(word_in[c])
    );
  end

  assign flag_clr = flag_wr ? core_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
      unf <= '0;
      ovf <= '0;
    end else begin
      if (start) act <= en;
      unf <= (unf & ~flag_clr[1:0]) | set_unf;
      ovf <= (ovf & ~flag_clr[3:2]) | set_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              core_rdata <= '0;
    else if (pop_core[0]) core_rdata <= head[0];
    else if (pop_core[1]) core_rdata <= head[1];
    else if (flag_rd)     core_rdata <= W'(pack_flags(unf, ovf));
  end
endmodule

// File: rtl/dsf_chk.sv
module dsf_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_dir,
  input logic       fs_both,
  input logic       en_a,
  input logic       en_b,
  input logic       hang_dis,
  input logic       core_wr,
  input logic       core_rd,
  input logic       core_stall,
  input logic       fs,
  input logic       tx_a,
  input logic       tx_b,
  input logic       start,
  input logic [1:0] full,
  input logic [1:0] empty,
  input logic [1:0] unf,
  input logic [1:0] ovf,
  input logic       flag_wr,
  input logic [3:0] clr_bits
);
  AST_TX_JOINT: assert property (@(posedge clk) disable iff (rst)
    (start && tx_dir && fs_both && en_a && en_b) |-> (!empty[0] && !empty[1])); // R1
  AST_TX_EITHER: assert property (@(posedge clk) disable iff (rst)
    (start && tx_dir) |-> ((en_a && !empty[0]) || (en_b && !empty[1]))); // R2
  AST_RX_JOINT: assert property (@(posedge clk) disable iff (rst)
    (start && !tx_dir && fs_both && en_a && en_b) |-> (!full[0] && !full[1])); // R3
  AST_START_FS: assert property (@(posedge clk) disable iff (rst)
    start |=> fs); // R6
  AST_FS_PULSE: assert property (@(posedge clk) disable iff (rst)
    fs |=> !fs); // R6
  AST_FS_QUIET: assert property (@(posedge clk) disable iff (rst)
    fs |-> (!tx_a && !tx_b)); // R6
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> (core_wr || core_rd)); // R8
  AST_NO_STALL_HD: assert property (@(posedge clk) disable iff (rst)
    hang_dis |-> !core_stall); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (unf[0] && !(flag_wr && clr_bits[0])) |=> unf[0]); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !(flag_wr && clr_bits[2])) |=> ovf[0]); // R10
endmodule

bind dual_sport_framer dsf_chk u_chk (
  .clk(clk), .rst(rst), .tx_dir(tx_dir), .fs_both(fs_both), .en_a(en_a), .en_b(en_b),
  .hang_dis(hang_dis), .core_wr(core_wr), .core_rd(core_rd), .core_stall(core_stall),
  .fs(fs), .tx_a(tx_a), .tx_b(tx_b), .start(start), .full(full), .empty(empty),
  .unf(unf), .ovf(ovf), .flag_wr(flag_wr), .clr_bits(core_wdata[3:0])
);

// File: tb/test_dual_sport_framer.sv
`timescale 1ns/1ps
module test_dual_sport_framer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, tx_dir, en_a, en_b, fs_both, hang_dis, core_wr, core_rd, rx_a, rx_b;
  logic [1:0]   core_addr;
  logic [W-1:0] core_wdata, core_rdata;
  logic core_stall, fs, tx_a, tx_b;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_sport_framer #(.W(W), .DEPTH(2)) i_dual_sport_framer (
    .clk(clk), .rst(rst), .tx_dir(tx_dir), .en_a(en_a), .en_b(en_b), .fs_both(fs_both),
    .hang_dis(hang_dis), .core_wr(core_wr), .core_rd(core_rd), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_stall(core_stall),
    .fs(fs), .tx_a(tx_a), .tx_b(tx_b), .rx_a(rx_a), .rx_b(rx_b)
  );

  // [6]tx [5]both [4]en_a [3]en_b [2]fill A [1]fill B [0]frame expected
  localparam logic [6:0] VEC [8] = '{
    7'b1111100, 7'b1111111, 7'b1011101, 7'b1011000,
    7'b1110101, 7'b1101100, 7'b1101011, 7'b0111001
  };

  function automatic string row_tag(input int v);
    case (v)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 6:    return "R4";
      5:       return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_dir = 1'b1; en_a = 1'b0; en_b = 1'b0; fs_both = 1'b0; hang_dis = 1'b1;
    core_wr = 1'b0; core_rd = 1'b0; core_addr = 2'd0; core_wdata = '0; rx_a = 1'b0; rx_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic core_access(input logic wr, input logic [1:0] addr, input logic [W-1:0] data,
                             output logic saw_stall);
    saw_stall = 1'b0;
    core_addr = addr; core_wdata = data; core_wr = wr; core_rd = ~wr;
    for (int i = 0; i < 40; i++) begin
      #2;
      if (!core_stall) break;
      saw_stall = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    core_wr = 1'b0; core_rd = 1'b0;
  endtask

  task automatic core_write(input logic [1:0] addr, input logic [W-1:0] data);
    logic s;
    core_access(1'b1, addr, data, s);
  endtask

  task automatic core_read(input logic [1:0] addr, output logic [W-1:0] data);
    logic s;
    core_access(1'b0, addr, '0, s);
    data = core_rdata;
  endtask

  task automatic wait_fs(output logic ok, output int waited);
    ok = 1'b0; waited = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      waited++;
      if (fs) begin ok = 1'b1; break; end
    end
  endtask

  task automatic tx_frame(output logic [W-1:0] wa, output logic [W-1:0] wb, output logic ok);
    int n;
    wa = '0; wb = '0;
    wait_fs(ok, n);
    if (ok) for (int i = 0; i < W; i++) begin
      @(negedge clk);
      wa = {wa[W-2:0], tx_a};
      wb = {wb[W-2:0], tx_b};
    end
  endtask

  task automatic rx_frame(input logic [W-1:0] wa, input logic [W-1:0] wb, output logic ok);
    int n;
    wait_fs(ok, n);
    if (ok) for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      rx_a = wa[i]; rx_b = wb[i];
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ok, s;
    logic [W-1:0] wa, wb, rd;
    int n;

    // R11 reset state
    do_reset();
    check("R11 fs after reset", fs, 0);
    check("R11 stall after reset", core_stall, 0);
    check("R11 rdata after reset", core_rdata, 0);
    core_read(2'd2, rd);
    check("R11 flags after reset", rd, 0);

    // gating table: R1 R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      logic seen;
      do_reset();
      tx_dir = VEC[v][6];
      if (VEC[v][2]) core_write(2'd0, 16'h1111);
      if (VEC[v][1]) core_write(2'd1, 16'h2222);
      fs_both = VEC[v][5]; en_a = VEC[v][4]; en_b = VEC[v][3];
      seen = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (fs) seen = 1'b1;
      end
      check(row_tag(v), seen, VEC[v][0]);
    end

    // R6 parallel MSB-first frame in joint mode
    do_reset();
    core_write(2'd0, 16'hA5C3);
    core_write(2'd1, 16'h1E0F);
    fs_both = 1'b1; en_a = 1'b1; en_b = 1'b1;
    tx_frame(wa, wb, ok);
    check("R6 frame seen", ok, 1);
    check("R6 lane A word", wa, 16'hA5C3);
    check("R6 lane B word", wb, 16'h1E0F);

    // R7 underflow on lane B, flags W1C (R10 R12)
    do_reset();
    core_write(2'd0, 16'h8001);
    en_a = 1'b1; en_b = 1'b1;
    tx_frame(wa, wb, ok);
    check("R7 lane A word", wa, 16'h8001);
    check("R7 lane B zeros", wb, 16'h0000);
    en_a = 1'b0; en_b = 1'b0;
    core_read(2'd2, rd);
    check("R7 underflow flag", rd, 16'h0002);
    core_write(2'd2, 16'h0002);
    core_read(2'd2, rd);
    check("R10 flag cleared by write", rd, 16'h0000);

    // R8 write stall until buffer drains
    do_reset();
    hang_dis = 1'b0;
    core_write(2'd0, 16'h0101);
    core_write(2'd0, 16'h0202);
    core_addr = 2'd0; core_wdata = 16'h0303; core_wr = 1'b1;
    #2;
    check("R8 stall on full write", core_stall, 1);
    @(negedge clk);
    @(negedge clk);
    check("R8 stall held", core_stall, 1);
    en_a = 1'b1;
    fork
      begin
        logic rel;
        rel = 1'b0;
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          if (!core_stall) begin rel = 1'b1; break; end
        end
        check("R8 stall released", rel, 1);
        @(negedge clk);
        core_wr = 1'b0;
      end
      begin
        logic [W-1:0] a1, a2, a3, b0;
        logic o1, o2, o3;
        tx_frame(a1, b0, o1);
        tx_frame(a2, b0, o2);
        tx_frame(a3, b0, o3);
        check("R8 word1", a1, 16'h0101);
        check("R8 word2", a2, 16'h0202);
        check("R8 stalled word completes", a3, 16'h0303);
        check("R5 disabled lane B quiet", b0, 16'h0000);
      end
    join

    // R9 dropped write, R6 back-to-back period
    do_reset();
    core_write(2'd0, 16'h00AA);
    core_write(2'd0, 16'h00BB);
    core_access(1'b1, 2'd0, 16'h00CC, s);
    check("R9 no stall on full write", s, 0);
    en_a = 1'b1;
    tx_frame(wa, wb, ok);
    check("R9 first word", wa, 16'h00AA);
    wait_fs(ok, n);
    check("R6 frame period W+2", n, 2);
    for (int i = 0; i < W; i++) @(negedge clk);
    wait_fs(ok, n);
    check("R9 dropped write never sent", ok, 0);

    // receive path: R8 read stall, R3 joint block, R10 overflow, R9 stale
    do_reset();
    tx_dir = 1'b0; hang_dis = 1'b0;
    core_addr = 2'd0; core_rd = 1'b1;
    #2;
    check("R8 stall on empty read", core_stall, 1);
    @(negedge clk);
    core_rd = 1'b0;
    en_a = 1'b1; en_b = 1'b1;
    rx_frame(16'h1234, 16'h5678, ok);
    check("R6 rx frame 1", ok, 1);
    rx_frame(16'h9ABC, 16'hDEF0, ok);
    check("R6 rx frame 2", ok, 1);
    fs_both = 1'b1;
    @(negedge clk);
    core_read(2'd1, rd);
    check("R6 lane B fifo order 1", rd, 16'h5678);
    core_read(2'd1, rd);
    check("R6 lane B fifo order 2", rd, 16'hDEF0);
    wait_fs(ok, n);
    check("R3 joint rx blocked by full A", ok, 0);
    fs_both = 1'b0;
    rx_frame(16'hFFFF, 16'h0F0F, ok);
    check("R2 non-joint rx frame", ok, 1);
    en_a = 1'b0; en_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    core_read(2'd2, rd);
    check("R10 overflow flag A", rd, 16'h0004);
    core_write(2'd2, 16'h0004);
    core_read(2'd2, rd);
    check("R10 overflow cleared", rd, 16'h0000);
    core_read(2'd0, rd);
    check("R10 A keeps old word 1", rd, 16'h1234);
    core_read(2'd0, rd);
    check("R10 A keeps old word 2", rd, 16'h9ABC);
    core_read(2'd1, rd);
    check("R12 lane B new word", rd, 16'h0F0F);
    hang_dis = 1'b1;
    core_access(1'b0, 2'd0, '0, s);
    check("R9 no stall on empty read", s, 0);
    check("R9 stale read data", core_rdata, 16'h0F0F);

    // R11 reset empties buffers
    do_reset();
    core_write(2'd0, 16'h4444);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    en_a = 1'b1;
    wait_fs(ok, n);
    check("R11 buffer emptied by reset", ok, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule